// File: doc/BRIEF.md
# Sample Trigger Scheduler

This block turns trigger events into start-of-conversion requests for a bank of sample slots. The slots come in two groups, A and B, of `NUM_PAIRS` each. Slot `i` below `NUM_PAIRS` is A slot `i`, and slot `NUM_PAIRS+i` is B slot `i`; these two form pair `i`. Each slot picks one of `NUM_SRC` trigger inputs and reacts to either the rising or the falling edge of that input. After the edge it waits a programmable number of ticks of a divided clock, then raises a pending request.

A pending request stays up until the converter pulses that slot's start-acknowledge input. Software can force a request on any slot through a write mask; a forced request skips the delay. An event that finds its slot still pending sets a sticky overrun flag, and a summary output ORs all of these flags together. A pair can be put in simultaneous mode. In that mode the B slot stops using its own trigger, and the A slot's request raises the B request in the same cycle.

Arbitration between converters and the conversion itself are outside this block.

Top module: `sample_trig_sched`

## Requirements
- R1: After reset, `pending`, `start_ovf` and `any_ovf` are all zero.
- R2: A slot whose `slot_fall_edge` bit is 0 reacts to a 0-to-1 transition of its selected input `trig_in[slot_src_sel]`.
- R3: A slot whose `slot_fall_edge` bit is 1 reacts only to a 1-to-0 transition. The opposite edge leaves its pending bit at 0.
- R4: For a delay count N > 0, the pending bit rises N×D clock edges after the edge that captures the trigger. The 2-bit divider code sets D: code 0 gives 1, code 1 gives 2, code 2 gives 4 and code 3 gives 16.
- R5: With a delay count of 0, the pending bit rises on the same clock edge that captures the trigger, which is one clock after the input changes.
- R6: When `sw_start_we` is high, each 1 bit of `sw_start_mask` sets that slot's pending bit on the next edge. Bits 0 to NUM_PAIRS-1 address group A and the bits above address group B. Bits that are 0 have no effect.
- R7: A pending bit holds until the clock edge on which `conv_start` for that slot is high, and clears there. A `conv_start` pulse to a slot that is not pending has no effect.
- R8: A request arriving while its slot is pending sets that slot's `start_ovf` bit. If `conv_start` for the slot is high in the same cycle, the pending bit is set again and no overrun is flagged.
- R9: An edge arriving while a slot's delay countdown is running sets that slot's `start_ovf` bit. The countdown is not restarted.
- R10: `start_ovf` bits are sticky. With `ovf_clr_we` high, each 1 bit of `ovf_clr_mask` clears that flag and each 0 bit leaves it alone. A set in the same cycle wins over a clear.
- R11: While `pair_simul[i]` is 1, every request from A slot `i`'s trigger path also sets B slot `i`'s pending bit on the same edge, and B slot `i`'s own trigger is ignored.
- R12: `any_ovf` is 1 exactly when at least one `start_ovf` bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_in | input | NUM_SRC | Trigger source inputs |
| slot_src_sel | input | NSLOT*SRC_W | Per-slot trigger source index |
| slot_fall_edge | input | NSLOT | Per-slot edge polarity: 0 rising, 1 falling |
| slot_dly_cnt | input | NSLOT*DLY_W | Per-slot delay count in divided ticks |
| slot_dly_div | input | NSLOT*2 | Per-slot delay divider code |
| pair_simul | input | NUM_PAIRS | Per-pair simultaneous mode |
| sw_start_we | input | 1 | Software start write strobe |
| sw_start_mask | input | NSLOT | Software start slot mask |
| ovf_clr_we | input | 1 | Overrun clear write strobe |
| ovf_clr_mask | input | NSLOT | Overrun clear mask (write 1 to clear) |
| conv_start | input | NSLOT | Per-slot start acknowledge from converter |
| pending | output | NSLOT | Per-slot pending request |
| start_ovf | output | NSLOT | Per-slot sticky start overrun flag |
| any_ovf | output | 1 | OR of all overrun flags |

## Verification
The assertions assume the following about the inputs:
- `conv_start` and the write strobes are single-cycle, synchronous pulses.
- Slot configuration does not change while that slot's countdown is running.
- Simultaneous mode is not switched while a B-slot countdown is in flight.

The stimulus respects these assumptions. It drives every input on the falling clock edge. It rewrites a slot's configuration only while that slot is idle and not pending. It keeps sources that are not under test still, so parked slots never see an edge.

// File: rtl/sts_pkg.sv
package sts_pkg;
  localparam int unsigned PRE_W = 4;

  // Terminal prescaler value for the 2-bit divider code: /1, /2, /4, /16
  function automatic logic [PRE_W-1:0] div_last(input logic [1:0] code);
    logic [PRE_W-1:0] r;
    case (code)
      2'd0:    r = 4'd0;
      2'd1:    r = 4'd1;
      2'd2:    r = 4'd3;
      default: r = 4'd15;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/sts_edge_detect.sv
module sts_edge_detect #(
  parameter int unsigned NUM_SRC = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] trig_in,
  output logic [NUM_SRC-1:0] rise,
  output logic [NUM_SRC-1:0] fall
);
  logic [NUM_SRC-1:0] prev_q, prev_d;

  always_comb begin
    prev_d = trig_in;
    rise   = trig_in & ~prev_q;
    fall   = ~trig_in & prev_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= prev_d;
  end

  // R2/R3: a detected edge always follows a change of the registered level
  a_r2_edge_change: assert property (@(posedge clk) disable iff (!rst_n)
    (rise != '0) |=> (prev_q != '0));
endmodule

// File: rtl/sts_trig_delay.sv
module sts_trig_delay
  import sts_pkg::*;
#(
  parameter int unsigned DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             edge_in,
  input  logic [DLY_W-1:0] dly_cnt,
  input  logic [1:0]       div_code,
  output logic             fire,
  output logic             ovr_edge
);
  logic             armed_q, armed_d;
  logic [DLY_W-1:0] cnt_q, cnt_d;
  logic [PRE_W-1:0] pre_q, pre_d;
  logic             tick, start_now;

  always_comb begin
    tick      = armed_q && (pre_q == div_last(div_code));
    start_now = edge_in && !armed_q;
    fire      = (start_now && (dly_cnt == '0)) || (tick && (cnt_q == DLY_W'(1)));
    ovr_edge  = edge_in && armed_q;
    armed_d   = armed_q;
    cnt_d     = cnt_q;
    pre_d     = pre_q;
    if (start_now && (dly_cnt != '0)) begin
      armed_d = 1'b1;
      cnt_d   = dly_cnt;
      pre_d   = '0;
    end else if (armed_q) begin
      if (tick) begin
        pre_d = '0;
        if (cnt_q == DLY_W'(1)) armed_d = 1'b0;
        else                    cnt_d   = cnt_q - DLY_W'(1);
      end else begin
        pre_d = pre_q + PRE_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
      pre_q   <= '0;
    end else begin
      armed_q <= armed_d;
      cnt_q   <= cnt_d;
      pre_q   <= pre_d;
    end
  end

  // R4: a running countdown never sits at zero
  a_r4_cnt_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |-> (cnt_q != '0));
  // R9: an edge during the countdown does not reload the count
  a_r9_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && edge_in && !tick) |=> (cnt_q == $past(cnt_q)));
  // R5: a zero delay never arms the countdown
  a_r5_zero_delay: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_in && !armed_q && (dly_cnt == '0)) |=> !armed_q);
endmodule

// File: rtl/sts_slot_ctrl.sv
module sts_slot_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic req_evt,
  input  logic ack,
  input  logic ovr_edge,
  input  logic ovf_clr,
  output logic pend,
  output logic ovf
);
  logic pend_q, pend_d, ovf_q, ovf_d, ovf_set;

  always_comb begin
    ovf_set = (req_evt && pend_q && !ack) || ovr_edge;
    if (req_evt)  pend_d = 1'b1;
    else if (ack) pend_d = 1'b0;
    else          pend_d = pend_q;
    if (ovf_set)      ovf_d = 1'b1;
    else if (ovf_clr) ovf_d = 1'b0;
    else              ovf_d = ovf_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      ovf_q  <= ovf_d;
    end
  end

  assign pend = pend_q;
  assign ovf  = ovf_q;

  a_r7_pend_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !ack) |=> pend_q);
  a_r7_ack_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && ack && !req_evt) |=> !pend_q);
  a_r10_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !ovf_clr) |=> ovf_q);
  a_r8_ack_race: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && ack && req_evt && !ovr_edge && !ovf_q) |=> (pend_q && !ovf_q));
endmodule

// File: rtl/sample_trig_sched.sv
module sample_trig_sched #(
  parameter int unsigned NUM_PAIRS = 8,
  parameter int unsigned NUM_SRC   = 8,
  parameter int unsigned DLY_W     = 8,
  parameter int unsigned NSLOT     = 2 * NUM_PAIRS,
  parameter int unsigned SRC_W     = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_SRC-1:0]     trig_in,
  input  logic [NSLOT*SRC_W-1:0] slot_src_sel,
  input  logic [NSLOT-1:0]       slot_fall_edge,
  input  logic [NSLOT*DLY_W-1:0] slot_dly_cnt,
  input  logic [NSLOT*2-1:0]     slot_dly_div,
  input  logic [NUM_PAIRS-1:0]   pair_simul,
  input  logic                   sw_start_we,
  input  logic [NSLOT-1:0]       sw_start_mask,
  input  logic                   ovf_clr_we,
  input  logic [NSLOT-1:0]       ovf_clr_mask,
  input  logic [NSLOT-1:0]       conv_start,
  output logic [NSLOT-1:0]       pending,
  output logic [NSLOT-1:0]       start_ovf,
  output logic                   any_ovf
);
  logic [NUM_SRC-1:0] rise, fall;
  logic [NSLOT-1:0]   edge_sel, edge_gated, fire, hw_req, ovr_edge, req_evt;

  sts_edge_detect #(.NUM_SRC(NUM_SRC)) u_edge (
    .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .rise(rise), .fall(fall));

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    localparam int unsigned PAIR = i % NUM_PAIRS;
    logic [SRC_W-1:0] src;

    always_comb begin
      src         = slot_src_sel[i*SRC_W +: SRC_W];
      edge_sel[i] = slot_fall_edge[i] ? fall[src] : rise[src];
    end

    if (i >= NUM_PAIRS) begin : g_b
      always_comb begin
        edge_gated[i] = edge_sel[i] && !pair_simul[PAIR];
        hw_req[i]     = pair_simul[PAIR] ? fire[PAIR] : fire[i];
      end
      // R11: the A request of a simultaneous pair lands on the B slot too
      a_r11_pair_follow: assert property (@(posedge clk) disable iff (!rst_n)
        (pair_simul[PAIR] && fire[PAIR]) |=> pending[i]);
    end else begin : g_a
      always_comb begin
        edge_gated[i] = edge_sel[i];
        hw_req[i]     = fire[i];
      end
    end

    always_comb req_evt[i] = hw_req[i] || (sw_start_we && sw_start_mask[i]);

    sts_trig_delay #(.DLY_W(DLY_W)) u_dly (
      .clk(clk), .rst_n(rst_n), .edge_in(edge_gated[i]),
      .dly_cnt(slot_dly_cnt[i*DLY_W +: DLY_W]), .div_code(slot_dly_div[i*2 +: 2]),
      .fire(fire[i]), .ovr_edge(ovr_edge[i]));

    sts_slot_ctrl u_ctl (
      .clk(clk), .rst_n(rst_n), .req_evt(req_evt[i]), .ack(conv_start[i]),
      .ovr_edge(ovr_edge[i]), .ovf_clr(ovf_clr_we && ovf_clr_mask[i]),
      .pend(pending[i]), .ovf(start_ovf[i]));

    // R6: a software start mask bit always produces a pending request
    a_r6_sw_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_start_we && sw_start_mask[i]) |=> pending[i]);
  end

  assign any_ovf = |start_ovf;

  // R12: a new overrun always shows up on the summary
  a_r12_summary: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ovr_edge) != '0) |-> any_ovf);
endmodule

// File: tb/tb_sample_trig_sched.sv
module tb_sample_trig_sched;
  localparam int NP = 8, NS = 8, DW = 8, NSL = 16, SW = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic [NS-1:0]     trig_in;
  logic [NSL*SW-1:0] src_sel;
  logic [NSL-1:0]    fall_sel;
  logic [NSL*DW-1:0] dly;
  logic [NSL*2-1:0]  dv;
  logic [NP-1:0]     simul;
  logic              sw_we, clr_we;
  logic [NSL-1:0]    sw_mask, clr_mask, ack;
  logic [NSL-1:0]    pending, start_ovf;
  logic              any_ovf;

  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  sample_trig_sched #(.NUM_PAIRS(NP), .NUM_SRC(NS), .DLY_W(DW)) dut (
    .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .slot_src_sel(src_sel),
    .slot_fall_edge(fall_sel), .slot_dly_cnt(dly), .slot_dly_div(dv),
    .pair_simul(simul), .sw_start_we(sw_we), .sw_start_mask(sw_mask),
    .ovf_clr_we(clr_we), .ovf_clr_mask(clr_mask), .conv_start(ack),
    .pending(pending), .start_ovf(start_ovf), .any_ovf(any_ovf));

  // {div code, delay count, falling, expected clocks from input change to pending}
  localparam logic [26:0] VEC [6] = '{
    {2'd0, 8'd0,   1'b0, 16'd1},
    {2'd0, 8'd5,   1'b0, 16'd6},
    {2'd1, 8'd3,   1'b1, 16'd7},
    {2'd2, 8'd4,   1'b0, 16'd17},
    {2'd3, 8'd2,   1'b1, 16'd33},
    {2'd3, 8'd255, 1'b0, 16'd4081}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic set_slot(input int s, input int src, input bit f, input int d, input int c);
    src_sel[s*SW +: SW] = SW'(src);
    fall_sel[s]         = f;
    dly[s*DW +: DW]     = DW'(d);
    dv[s*2 +: 2]        = 2'(c);
  endtask

  task automatic pulse_ack(input logic [NSL-1:0] m);
    @(negedge clk); ack = m;
    @(negedge clk); ack = '0;
  endtask

  task automatic sw_start(input logic [NSL-1:0] m);
    @(negedge clk); sw_we = 1'b1; sw_mask = m;
    @(negedge clk); sw_we = 1'b0; sw_mask = '0;
  endtask

  task automatic clr_ovf(input logic [NSL-1:0] m);
    @(negedge clk); clr_we = 1'b1; clr_mask = m;
    @(negedge clk); clr_we = 1'b0; clr_mask = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int n;
    rst_n = 1'b0; trig_in = '0; simul = '0; sw_we = 1'b0; clr_we = 1'b0;
    sw_mask = '0; clr_mask = '0; ack = '0;
    for (int s = 0; s < NSL; s++) set_slot(s, 7, 1'b0, 0, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 pending", 32'(pending), 0);
    chk("R1 start_ovf", 32'(start_ovf), 0);
    chk("R1 any_ovf", 32'(any_ovf), 0);

    // Table walk: polarity and delay/divider on slot 0, source 0
    for (int r = 0; r < 6; r++) begin
      logic f;
      f = VEC[r][16];
      set_slot(0, 0, f, int'(VEC[r][24:17]), int'(VEC[r][26:25]));
      @(negedge clk); trig_in[0] = f;
      repeat (3) @(negedge clk);
      chk("R3 opposite edge ignored", 32'(pending[0]), 0);
      trig_in[0] = ~f;
      n = 0;
      do begin @(negedge clk); n++; end while (!pending[0] && n < 5000);
      chk(r == 0 ? "R5 zero delay" : (f ? "R3/R4 falling delay" : "R2/R4 rising delay"),
          32'(n), 32'(VEC[r][15:0]));
      pulse_ack(16'h0001);
      chk("R7 ack clears", 32'(pending[0]), 0);
    end

    // R6 software start
    sw_start(16'h0000);
    chk("R6 zero mask no effect", 32'(pending), 0);
    sw_start(16'h0100);
    chk("R6 bit 8 is B slot 0", 32'(pending), 32'h0100);
    pulse_ack(16'h0100);

    // R7 hold and stray ack
    pulse_ack(16'h0008);
    chk("R7 stray ack no effect", 32'(pending), 0);
    sw_start(16'h0010);
    repeat (5) @(negedge clk);
    chk("R7 pending holds", 32'(pending[4]), 1);
    pulse_ack(16'h0010);
    chk("R7 ack clears slot 4", 32'(pending[4]), 0);

    // R8 overrun and ack race
    sw_start(16'h0004);
    sw_start(16'h0004);
    chk("R8 overrun set", 32'(start_ovf), 32'h0004);
    chk("R12 summary set", 32'(any_ovf), 1);
    sw_start(16'h0020);
    @(negedge clk); sw_we = 1'b1; sw_mask = 16'h0020; ack = 16'h0020;
    @(negedge clk); sw_we = 1'b0; sw_mask = '0; ack = '0;
    chk("R8 race keeps pending", 32'(pending[5]), 1);
    chk("R8 race no overrun", 32'(start_ovf[5]), 0);
    pulse_ack(16'h0020);

    // R10 clear behaviour
    clr_ovf(16'h0000);
    chk("R10 zero mask keeps flag", 32'(start_ovf[2]), 1);
    @(negedge clk); sw_we = 1'b1; sw_mask = 16'h0004; clr_we = 1'b1; clr_mask = 16'h0004;
    @(negedge clk); sw_we = 1'b0; sw_mask = '0; clr_we = 1'b0; clr_mask = '0;
    chk("R10 set wins over clear", 32'(start_ovf[2]), 1);
    clr_ovf(16'h0004);
    chk("R10 write 1 clears", 32'(start_ovf[2]), 0);
    chk("R12 summary clear", 32'(any_ovf), 0);
    pulse_ack(16'h0004);

    // R9 edge during countdown
    set_slot(1, 1, 1'b0, 10, 0);
    @(negedge clk); trig_in[1] = 1'b1;
    @(negedge clk); trig_in[1] = 1'b0;
    @(negedge clk); trig_in[1] = 1'b1;
    @(negedge clk);
    chk("R9 overrun on second edge", 32'(start_ovf[1]), 1);
    repeat (7) @(negedge clk);
    chk("R9 not yet pending", 32'(pending[1]), 0);
    @(negedge clk);
    chk("R9 countdown not restarted", 32'(pending[1]), 1);
    pulse_ack(16'h0002);
    clr_ovf(16'h0002);

    // R11 simultaneous pair 3
    set_slot(3, 4, 1'b0, 0, 0);
    set_slot(11, 5, 1'b0, 0, 0);
    simul[3] = 1'b1;
    @(negedge clk); trig_in[5] = 1'b1;
    @(negedge clk);
    chk("R11 B trigger ignored", 32'(pending), 0);
    trig_in[4] = 1'b1;
    @(negedge clk);
    chk("R11 A starts both", 32'(pending), 32'h0808);
    pulse_ack(16'h0808);
    simul[3] = 1'b0;
    @(negedge clk); trig_in[5] = 1'b0;
    @(negedge clk); trig_in[5] = 1'b1;
    @(negedge clk);
    chk("R11 single mode B own trigger", 32'(pending), 32'h0800);
    chk("R12 no overrun", 32'(any_ovf), 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule